// File: doc/BRIEF.md
# Border-Aware Morphological Window Reducer

This block turns 3x3 pixel neighbourhoods into grey-level erosion, dilation or morphological gradient results. Every cycle an upstream extractor can present `LANES` adjacent windows from one image row, scanned in raster order. The block tracks where each window centre sits in the image. Window positions that fall past an image edge, and positions that the structuring-element mask leaves out, are replaced by a value that cannot change the result: the largest pixel code ahead of the minimum tree, zero ahead of the maximum tree. The reduction trees are pipelined. Each lane therefore returns one result per cycle, and the latency does not depend on the configuration.

Software programs the operation, the element mask and the image size while the block is idle. It then streams one frame of windows, with idle cycles allowed anywhere. The position tracking restarts by itself after the last window group of a frame, so frames can follow one another with no gap.

Top module: `morph_window_unit`

## Requirements
- R1: While reset is applied and in the first cycle after reset, `resValid` is low.
- R2: A window group accepted in one cycle (`winValid` high at a rising edge) produces exactly one `resValid` cycle. That result is visible after the 8th rising edge, counting the accepting edge as the first. Results leave in input order, and `resValid` is never raised without a matching input.
- R3: Erosion (`cfgOp` = 2'b00) outputs the minimum of the selected window positions. If no position is selected, it outputs the all-ones pixel code.
- R4: Dilation (`cfgOp` = 2'b01) outputs the maximum of the selected window positions. If no position is selected, it outputs zero.
- R5: Gradient (`cfgOp[1]` = 1) outputs the dilation result minus the erosion result for the same window. If no position is selected, it outputs zero.
- R6: Window position k = 3*r + c holds row r (0 = above the centre) and column c (0 = left of the centre). Its pixel is at `winData[(lane*9 + k)*PIX_W +: PIX_W]`. A position is selected only if `cfgMask[k]` is 1. Bit 4 is the centre.
- R7: In the first image row, positions with r = 0 are deselected. In row `cfgHeight`-1, positions with r = 2 are deselected. A frame with a single row deselects both.
- R8: Lane i of a group whose first centre is at column C has its centre at column C+i. At column 0, positions with c = 0 are deselected. At column `cfgWidth`-1, positions with c = 2 are deselected.
- R9: The centre position starts at row 0, column 0 after reset. It advances by `LANES` columns on each accepted group and does not move on idle cycles. It wraps to column 0 of the next row at `cfgWidth`, and to row 0 after the last row, so a following frame starts aligned. `cfgWidth` must be a multiple of `LANES`.
- R10: The operation code is captured together with each group, so a code of 2'b11 also selects gradient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| winValid | input | 1 | A window group is present this cycle |
| winData | input | LANES*9*PIX_W | LANES windows of nine pixels each |
| cfgOp | input | 2 | Operation: 00 erosion, 01 dilation, 1x gradient |
| cfgMask | input | 9 | Structuring-element mask, bit k for window position k |
| cfgWidth | input | DIM_W | Image width in pixels |
| cfgHeight | input | DIM_W | Image height in rows |
| resValid | output | 1 | Results are present this cycle |
| resData | output | LANES*PIX_W | One result pixel per lane |

## Verification
Some properties are checked on every cycle. A result never appears without an input accepted eight edges earlier, and no result is driven while reset is fresh. With a centre-only mask, erosion and dilation must echo the centre pixel. With an empty mask, erosion must output all ones. Edge handling cannot be shown that way, because it depends on where each window lies in the frame. The bench's scenarios cover it: they track frame position independently across idle gaps, single-row frames and back-to-back frames, and compare every lane against a reference reduction.

// File: rtl/morph_pkg.sv
package morph_pkg;

  typedef enum logic [1:0] {
    OP_ERODE  = 2'b00,
    OP_DILATE = 2'b01,
    OP_GRAD   = 2'b10
  } morph_op_e;

  // Strobes from control to datapath, aligned as the comments say
  typedef struct packed {
    logic      rowTop;     // aligned with the stage-2 window
    logic      rowBottom;  // aligned with the stage-2 window
    morph_op_e outOp;      // aligned with the tree output
  } morph_strobe_t;

  function automatic morph_op_e decodeOp(input logic [1:0] code);
    if (code[1]) return OP_GRAD;
    return code[0] ? OP_DILATE : OP_ERODE;
  endfunction

  // Number of values left after `lvl` pairwise tree levels
  function automatic int treeSize(input int numIn, input int lvl);
    int s;
    s = numIn;
    for (int i = 0; i < lvl; i++) s = (s + 1) / 2;
    return s;
  endfunction

endpackage

// File: rtl/morph_reduce_tree.sv
module morph_reduce_tree #(
  parameter int PIX_W    = 8,
  parameter int NUM_IN   = 9,
  parameter bit TAKE_MAX = 1'b0
) (
  input  logic                    clk,
  input  logic [NUM_IN*PIX_W-1:0] inVals,
  output logic [PIX_W-1:0]        outVal
);
  import morph_pkg::*;

  localparam int LEVELS = $clog2(NUM_IN);

  for (genvar l = 0; l < LEVELS; l++) begin : lvl
    localparam int IN_N  = treeSize(NUM_IN, l);
    localparam int OUT_N = treeSize(NUM_IN, l + 1);
    logic [PIX_W-1:0] src [IN_N];
    logic [PIX_W-1:0] dst [OUT_N];

    for (genvar j = 0; j < IN_N; j++) begin : feed
      if (l == 0) begin : fromIn
        assign src[j] = inVals[j*PIX_W +: PIX_W];
      end else begin : fromPrev
        assign src[j] = lvl[l-1].dst[j];
      end
    end

    always_ff @(posedge clk) begin
      for (int j = 0; j < OUT_N; j++) begin
        logic [PIX_W-1:0] a, b;
        a = src[2*j];
        b = src[(2*j+1 < IN_N) ? (2*j+1) : (2*j)];
        if (TAKE_MAX) dst[j] <= (a > b) ? a : b;
        else          dst[j] <= (a < b) ? a : b;
      end
    end
  end

  assign outVal = lvl[LEVELS-1].dst[0];

endmodule

// File: rtl/morph_ctrl.sv
module morph_ctrl #(
  parameter int LANES       = 4,
  parameter int DIM_W       = 10,
  parameter int TREE_LEVELS = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     winValid,
  input  logic [1:0]               cfgOp,
  input  logic [DIM_W-1:0]         cfgWidth,
  input  logic [DIM_W-1:0]         cfgHeight,
  output morph_pkg::morph_strobe_t strobe,
  output logic [LANES-1:0]         leftEdge,
  output logic [LANES-1:0]         rightEdge,
  output logic                     resValid
);
  import morph_pkg::*;

  localparam int LATENCY  = 3 + TREE_LEVELS + 1;
  localparam int OP_DEPTH = 3 + TREE_LEVELS;
  localparam logic [DIM_W:0] LANE_STEP = (DIM_W+1)'(LANES);

  logic [DIM_W-1:0] colCnt, rowCnt;
  logic [DIM_W-1:0] colS1, rowS1;
  logic             rowTopS2, rowBottomS2;
  logic [LATENCY-1:0] validPipe;
  morph_op_e        opPipe [OP_DEPTH];

  // Stage 0/1: position counters, sampled alongside the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      colCnt <= '0;
      rowCnt <= '0;
    end else if (winValid) begin
      if ({1'b0, colCnt} + LANE_STEP >= {1'b0, cfgWidth}) begin
        colCnt <= '0;
        if ({1'b0, rowCnt} + 1'b1 >= {1'b0, cfgHeight}) rowCnt <= '0;
        else rowCnt <= rowCnt + 1'b1;
      end else begin
        colCnt <= colCnt + LANE_STEP[DIM_W-1:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    colS1 <= colCnt;
    rowS1 <= rowCnt;
  end

  // Stage 2: border comparators
  always_ff @(posedge clk) begin
    rowTopS2    <= (rowS1 == '0);
    rowBottomS2 <= (rowS1 == cfgHeight - 1'b1);
    for (int i = 0; i < LANES; i++) begin
      leftEdge[i]  <= ({1'b0, colS1} + (DIM_W+1)'(i) == '0);
      rightEdge[i] <= ({1'b0, colS1} + (DIM_W+1)'(i) == {1'b0, cfgWidth} - 1'b1);
    end
  end

  // Operation follows its window down the pipe
  always_ff @(posedge clk) begin
    opPipe[0] <= decodeOp(cfgOp);
    for (int j = 1; j < OP_DEPTH; j++) opPipe[j] <= opPipe[j-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) validPipe <= '0;
    else       validPipe <= {validPipe[LATENCY-2:0], winValid};
  end

  assign strobe.rowTop    = rowTopS2;
  assign strobe.rowBottom = rowBottomS2;
  assign strobe.outOp     = opPipe[OP_DEPTH-1];
  assign resValid         = validPipe[LATENCY-1];

endmodule

// File: rtl/morph_datapath.sv
module morph_datapath #(
  parameter int LANES = 4,
  parameter int PIX_W = 8
) (
  input  logic                     clk,
  input  logic [LANES*9*PIX_W-1:0] winData,
  input  logic [8:0]               cfgMask,
  input  morph_pkg::morph_strobe_t strobe,
  input  logic [LANES-1:0]         leftEdge,
  input  logic [LANES-1:0]         rightEdge,
  output logic [LANES*PIX_W-1:0]   resData
);
  import morph_pkg::*;

  localparam int WIN_W = 9 * PIX_W;
  localparam logic [PIX_W-1:0] PIX_MAX = '1;

  for (genvar i = 0; i < LANES; i++) begin : lane
    logic [WIN_W-1:0] s1Win, s2Win, minIn, maxIn;
    logic [8:0]       keep;
    logic [PIX_W-1:0] minOut, maxOut, laneOut;

    always_ff @(posedge clk) begin
      s1Win <= winData[i*WIN_W +: WIN_W];
      s2Win <= s1Win;
    end

    // Selection: element mask and off-image exclusion
    always_comb begin
      for (int k = 0; k < 9; k++) begin
        keep[k] = cfgMask[k];
        if (k < 3 && strobe.rowTop)         keep[k] = 1'b0;
        if (k >= 6 && strobe.rowBottom)     keep[k] = 1'b0;
        if ((k % 3) == 0 && leftEdge[i])    keep[k] = 1'b0;
        if ((k % 3) == 2 && rightEdge[i])   keep[k] = 1'b0;
      end
    end

    // Stage 3: neutral-value substitution
    always_ff @(posedge clk) begin
      for (int k = 0; k < 9; k++) begin
        minIn[k*PIX_W +: PIX_W] <= keep[k] ? s2Win[k*PIX_W +: PIX_W] : PIX_MAX;
        maxIn[k*PIX_W +: PIX_W] <= keep[k] ? s2Win[k*PIX_W +: PIX_W] : '0;
      end
    end

    morph_reduce_tree #(.PIX_W(PIX_W), .NUM_IN(9), .TAKE_MAX(1'b0)) minTree (
      .clk(clk), .inVals(minIn), .outVal(minOut)
    );
    morph_reduce_tree #(.PIX_W(PIX_W), .NUM_IN(9), .TAKE_MAX(1'b1)) maxTree (
      .clk(clk), .inVals(maxIn), .outVal(maxOut)
    );

    always_ff @(posedge clk) begin
      unique case (strobe.outOp)
        OP_ERODE:  laneOut <= minOut;
        OP_DILATE: laneOut <= maxOut;
        default:   laneOut <= (maxOut >= minOut) ? (maxOut - minOut) : '0;
      endcase
    end

    assign resData[i*PIX_W +: PIX_W] = laneOut;
  end

endmodule

// File: rtl/morph_window_unit.sv
module morph_window_unit #(
  parameter int LANES = 4,
  parameter int PIX_W = 8,
  parameter int DIM_W = 10
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     winValid,
  input  logic [LANES*9*PIX_W-1:0] winData,
  input  logic [1:0]               cfgOp,
  input  logic [8:0]               cfgMask,
  input  logic [DIM_W-1:0]         cfgWidth,
  input  logic [DIM_W-1:0]         cfgHeight,
  output logic                     resValid,
  output logic [LANES*PIX_W-1:0]   resData
);
  import morph_pkg::*;

  localparam int TREE_LEVELS = $clog2(9);

  morph_strobe_t    strobe;
  logic [LANES-1:0] leftEdge, rightEdge;

  morph_ctrl #(.LANES(LANES), .DIM_W(DIM_W), .TREE_LEVELS(TREE_LEVELS)) ctrl (
    .clk(clk), .rstN(rstN), .winValid(winValid), .cfgOp(cfgOp),
    .cfgWidth(cfgWidth), .cfgHeight(cfgHeight), .strobe(strobe),
    .leftEdge(leftEdge), .rightEdge(rightEdge), .resValid(resValid)
  );

  morph_datapath #(.LANES(LANES), .PIX_W(PIX_W)) datapath (
    .clk(clk), .winData(winData), .cfgMask(cfgMask), .strobe(strobe),
    .leftEdge(leftEdge), .rightEdge(rightEdge), .resData(resData)
  );

endmodule

// File: rtl/morph_window_unit_chk.sv
module morph_window_unit_chk #(
  parameter int LANES = 4,
  parameter int PIX_W = 8
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     winValid,
  input logic [LANES*9*PIX_W-1:0] winData,
  input logic [1:0]               cfgOp,
  input logic [8:0]               cfgMask,
  input logic                     resValid,
  input logic [LANES*PIX_W-1:0]   resData
);
  logic wasReset;

  always_ff @(posedge clk) begin
    wasReset <= !rstN;
    // R1
    if (wasReset && rstN) begin
      reset_idle_chk: assert (!resValid) else $error("result valid straight after reset");
    end
  end

  // R2
  valid_origin_chk: assert property (@(posedge clk) disable iff (!rstN)
    resValid |-> $past(winValid, 8));

  // R2
  data_known_chk: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> !$isunknown(winData));

  for (genvar i = 0; i < LANES; i++) begin : laneChk
    // R6
    centre_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      (resValid && cfgMask == 9'h010 && !cfgOp[1])
        |-> resData[i*PIX_W +: PIX_W] == $past(winData[(i*9+4)*PIX_W +: PIX_W], 8));

    // R3
    empty_erode_chk: assert property (@(posedge clk) disable iff (!rstN)
      (resValid && cfgMask == 9'h000 && cfgOp == 2'b00)
        |-> resData[i*PIX_W +: PIX_W] == {PIX_W{1'b1}});
  end

endmodule

bind morph_window_unit morph_window_unit_chk #(.LANES(LANES), .PIX_W(PIX_W)) chk (
  .clk(clk), .rstN(rstN), .winValid(winValid), .winData(winData),
  .cfgOp(cfgOp), .cfgMask(cfgMask), .resValid(resValid), .resData(resData)
);

// File: tb/tb_morph_window_unit.sv
`timescale 1ns/1ps
module tb_morph_window_unit;
  localparam int LANES = 4;
  localparam int PIX_W = 8;
  localparam int DIM_W = 10;

  logic                     clk = 1'b0;
  logic                     rstN = 1'b0;
  logic                     winValid = 1'b0;
  logic [LANES*9*PIX_W-1:0] winData = '0;
  logic [1:0]               cfgOp = 2'b00;
  logic [8:0]               cfgMask = 9'h1FF;
  logic [DIM_W-1:0]         cfgWidth = 10'd8;
  logic [DIM_W-1:0]         cfgHeight = 10'd3;
  logic                     resValid;
  logic [LANES*PIX_W-1:0]   resData;

  int compared = 0;
  int mismatched = 0;
  int bCol = 0;
  int bRow = 0;
  logic [PIX_W-1:0] expQ [$];
  string            tagQ [$];

  always #2.5 clk = ~clk;

  morph_window_unit #(.LANES(LANES), .PIX_W(PIX_W), .DIM_W(DIM_W)) dut (
    .clk(clk), .rstN(rstN), .winValid(winValid), .winData(winData),
    .cfgOp(cfgOp), .cfgMask(cfgMask), .cfgWidth(cfgWidth), .cfgHeight(cfgHeight),
    .resValid(resValid), .resData(resData)
  );

  task automatic check(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [PIX_W-1:0] refLane(input logic [9*PIX_W-1:0] win,
      input logic [8:0] mask, input logic [1:0] op, input int col, input int row,
      input int w, input int h);
    int mn = 255, mx = 0;
    for (int k = 0; k < 9; k++) begin
      bit sel = mask[k];
      int r = k / 3, c = k % 3;
      int v = win[k*PIX_W +: PIX_W];
      if (r == 0 && row == 0) sel = 0;
      if (r == 2 && row == h - 1) sel = 0;
      if (c == 0 && col == 0) sel = 0;
      if (c == 2 && col == w - 1) sel = 0;
      if (sel) begin
        if (v < mn) mn = v;
        if (v > mx) mx = v;
      end
    end
    if (op == 2'b00) return PIX_W'(mn);
    if (op == 2'b01) return PIX_W'(mx);
    return (mx >= mn) ? PIX_W'(mx - mn) : '0;
  endfunction

  // Result monitor, compares in order against the reference queue
  always @(negedge clk) begin
    if (rstN && resValid) begin
      for (int i = 0; i < LANES; i++) begin
        if (expQ.size() == 0) check("R2 unexpected result", 1, 0);
        else begin
          automatic logic [PIX_W-1:0] e = expQ.pop_front();
          automatic string t = tagQ.pop_front();
          check(t, resData[i*PIX_W +: PIX_W], e);
        end
      end
    end
  end

  task automatic driveGroup(input string tag);
    @(negedge clk);
    for (int b = 0; b < LANES*9; b++) winData[b*PIX_W +: PIX_W] = PIX_W'($urandom);
    winValid = 1'b1;
    for (int i = 0; i < LANES; i++) begin
      expQ.push_back(refLane(winData[i*9*PIX_W +: 9*PIX_W], cfgMask, cfgOp,
                             bCol + i, bRow, int'(cfgWidth), int'(cfgHeight)));
      tagQ.push_back(tag);
    end
    bCol += LANES;
    if (bCol >= int'(cfgWidth)) begin
      bCol = 0;
      bRow = (bRow + 1 >= int'(cfgHeight)) ? 0 : bRow + 1;
    end
  endtask

  task automatic idle(input int n);
    for (int j = 0; j < n; j++) begin
      @(negedge clk);
      winValid = 1'b0;
    end
  endtask

  task automatic drain(input string tag);
    idle(12);
    check({tag, " all results returned"}, expQ.size(), 0);
  endtask

  task automatic setCfg(input int w, input int h, input logic [8:0] m, input logic [1:0] op);
    @(negedge clk);
    winValid = 1'b0;
    cfgWidth = DIM_W'(w); cfgHeight = DIM_W'(h); cfgMask = m; cfgOp = op;
  endtask

  task automatic runFrame(input string tag, input int gapMax);
    int groups = int'(cfgWidth) / LANES * int'(cfgHeight);
    for (int g = 0; g < groups; g++) begin
      driveGroup(tag);
      if (gapMax > 0) idle($urandom_range(gapMax, 0));
    end
  endtask

  task automatic testReset();
    check("R1 resValid in reset", resValid, 0);
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check("R1 resValid after reset", resValid, 0);
  endtask

  task automatic testLatency();
    int n = 0;
    setCfg(4, 1, 9'h1FF, 2'b00);
    driveGroup("R2 latency data");
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      if (n == 1) winValid = 1'b0;
    end while (!resValid && n < 20);
    check("R2 latency in edges", n, 8);
    drain("R2");
  endtask

  task automatic testErosion();
    setCfg(8, 3, 9'h1FF, 2'b00);
    runFrame("R3 R7 R8 erosion full element", 0);
    drain("R3");
  endtask

  task automatic testDilationCross();
    setCfg(12, 4, 9'h0BA, 2'b01);
    runFrame("R4 R6 R9 dilation cross with gaps", 2);
    drain("R4");
  endtask

  task automatic testGradient();
    setCfg(8, 2, 9'h111, 2'b10);
    runFrame("R5 R6 gradient diagonal", 1);
    drain("R5");
  endtask

  task automatic testEmptyMask();
    setCfg(8, 2, 9'h000, 2'b00);
    runFrame("R3 empty mask erosion", 0);
    drain("R3 empty");
    setCfg(8, 2, 9'h000, 2'b10);
    runFrame("R5 empty mask gradient", 0);
    drain("R5 empty");
  endtask

  task automatic testBackToBack();
    setCfg(8, 2, 9'h1FF, 2'b01);
    runFrame("R9 frame one", 0);
    runFrame("R9 frame two wraps", 0);
    drain("R9");
  endtask

  task automatic testOpCode3();
    setCfg(4, 1, 9'h1FF, 2'b11);
    runFrame("R10 R7 code 11 single row", 0);
    runFrame("R10 R7 code 11 again", 0);
    drain("R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    testLatency();
    testErosion();
    testDilationCross();
    testGradient();
    testEmptyMask();
    testBackToBack();
    testOpCode3();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule